// File: doc/BRIEF.md
# Three-Phase Bridge Gate Command Conditioner

This block sits between a motor controller and the gate drivers of a three-phase half-bridge. Each phase has two active-low command inputs, one for the upper switch and one for the lower switch. Each command is brought into the clock domain, then passed through a minimum-width filter. A per-phase controller turns the commands into two active-high gate enables. It refuses to drive both switches of a phase together, and it keeps both switches off for a fixed interval before either one turns on.

A global disable input, driven by undervoltage or fault logic, forces all gate enables off. While the disable is active, the commands have no effect. Once it is released, every phase waits a full dead-time interval before it drives any switch. Each phase also has a one-cycle switching-event output. It marks every edge of that phase's gate enables, so that current-sense blanking logic can use it.

Timing comes from counters on one clock. With the default parameters and a 50 MHz clock, the filter is 15 cycles (300 ns) and the dead time is 100 cycles (2 µs).

Top module: `bridge_input_cond`

## Requirements
- R1: Command inputs are active low: 0 requests the switch. Gate enables and event outputs are active high. During reset and directly after it, every gate enable and every event output is 0.
- R2: A command level reaches the gate logic only after it has held for FILT_CYC consecutive clock cycles. A pulse shorter than that has no effect on any output. A pulse of exactly FILT_CYC cycles is passed through. With the dead time already satisfied, a gate enable follows a command change FILT_CYC+3 cycles after the input is first sampled.
- R3: When the filtered upper and lower commands of a phase are both active, both gate enables of that phase are 0, whichever command came first. The two gate enables of a phase are never 1 together.
- R4: The lockout lasts as long as both filtered commands stay active. When one of them is withdrawn, the other side turns on with the normal latency, provided the dead time has already elapsed.
- R5: After a gate enable of a phase falls, neither gate enable of that phase rises until both have been 0 for DEAD_CYC consecutive cycles. In a direct hand-over from one side to the other, the second side rises exactly DEAD_CYC cycles after the first side falls.
- R6: Three cycles after the disable input goes to 1, all gate enables are 0. They stay 0, whatever the commands do, until the disable is released.
- R7: After the disable returns to 0, a requested gate enable rises DEAD_CYC+2 cycles after the release is first sampled, and not earlier.
- R8: A phase's event output is 1 for exactly the cycle in which either of that phase's gate enables has just changed, and 0 otherwise.
- R9: Phases are independent: commands on one phase do not change the gate enables of another phase.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| hi_cmd_n | input | NUM_PHASES | Upper-switch commands, active low, bit 0 is phase A |
| lo_cmd_n | input | NUM_PHASES | Lower-switch commands, active low, bit 0 is phase A |
| drv_disable | input | 1 | Global disable (undervoltage/fault), active high |
| hi_gate_en | output | NUM_PHASES | Upper-switch gate enables, active high |
| lo_gate_en | output | NUM_PHASES | Lower-switch gate enables, active high |
| sw_event | output | NUM_PHASES | One-cycle pulse on any gate-enable edge of the phase |

## Verification
The bench aims at the edges of the filter window. It drives a pulse one cycle shorter than the window and one of exactly the window length; a filter counting off by one would either pass the short glitch or drop the legal pulse. It measures the hand-over gap to the exact cycle and the delay after a disable release. A dead-time counter that starts late, saturates early or is not cleared by the disable shows up as a gate rising one cycle early or late. It also holds both commands of one phase active across a full dead-time interval, and changes commands while the disable is active. A design that gave one side priority, or that latched commands during the disable, would raise a gate when it should not.

// File: rtl/bic_pkg.sv
package bic_pkg;

    // Gate pair of one phase, active high.
    typedef struct packed {
        logic hi;
        logic lo;
    } gate_pair_t;

endpackage

// File: rtl/bic_sync.sv
module bic_sync #(
    parameter int        W       = 1,
    parameter logic      RST_VAL = 1'b0
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] async_i,
    output logic [W-1:0] sync_o
);

    typedef struct packed {
        logic [W-1:0] s1;
        logic [W-1:0] s2;
    } sync_state_t;

    sync_state_t st_d, st_q;

    always_comb begin
        st_d    = st_q;
        st_d.s1 = async_i;
        st_d.s2 = st_q.s1;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q.s1 <= {W{RST_VAL}};
            st_q.s2 <= {W{RST_VAL}};
        end else begin
            st_q <= st_d;
        end
    end

    assign sync_o = st_q.s2;

endmodule

// File: rtl/bic_glitch_filter.sv
module bic_glitch_filter #(
    parameter int FILT_CYC = 15
) (
    input  logic clk,
    input  logic rst_n,
    input  logic raw_i,
    output logic filt_o
);

    localparam int CW = (FILT_CYC > 2) ? $clog2(FILT_CYC) : 1;
    localparam logic [CW-1:0] CNT_LAST = CW'(FILT_CYC - 1);

    typedef struct packed {
        logic          lvl;
        logic [CW-1:0] cnt;
    } filt_state_t;

    filt_state_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (raw_i == st_q.lvl) begin
            st_d.cnt = '0;
        end else if (st_q.cnt == CNT_LAST) begin
            st_d.lvl = raw_i;
            st_d.cnt = '0;
        end else begin
            st_d.cnt = st_q.cnt + 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign filt_o = st_q.lvl;

    // R2: the filtered level moves only after a full window of disagreement.
    p_filter_window_r2: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(st_q.lvl) |-> ($past(st_q.cnt) == CNT_LAST));

endmodule

// File: rtl/bic_phase_ctrl.sv
module bic_phase_ctrl
    import bic_pkg::*;
#(
    parameter int DEAD_CYC = 100
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       hi_req_i,
    input  logic       lo_req_i,
    input  logic       dis_i,
    output gate_pair_t gate_o,
    output logic       event_o
);

    localparam int IW = (DEAD_CYC > 2) ? $clog2(DEAD_CYC) : 1;
    localparam logic [IW-1:0] IDLE_DONE = IW'(DEAD_CYC - 1);

    typedef struct packed {
        gate_pair_t    gate;
        logic [IW-1:0] idle;
        logic          ev;
    } phase_state_t;

    phase_state_t st_d, st_q;
    logic         dead_ok;
    logic         hi_only;
    logic         lo_only;

    always_comb begin
        st_d    = st_q;
        dead_ok = (st_q.idle == IDLE_DONE);
        hi_only = hi_req_i & ~lo_req_i;
        lo_only = lo_req_i & ~hi_req_i;

        st_d.gate.hi = ~dis_i & hi_only & (st_q.gate.hi | dead_ok);
        st_d.gate.lo = ~dis_i & lo_only & (st_q.gate.lo | dead_ok);

        if (dis_i || st_q.gate.hi || st_q.gate.lo) begin
            st_d.idle = '0;
        end else if (!dead_ok) begin
            st_d.idle = st_q.idle + 1'b1;
        end

        st_d.ev = (st_d.gate.hi ^ st_q.gate.hi) | (st_d.gate.lo ^ st_q.gate.lo);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign gate_o  = st_q.gate;
    assign event_o = st_q.ev;

    // R3: never both switches of a phase.
    p_no_overlap_r3: assert property (@(posedge clk) disable iff (!rst_n)
        !(st_q.gate.hi && st_q.gate.lo));

    // R5: a rising gate was preceded by a cycle with both gates off.
    p_gap_before_on_r5: assert property (@(posedge clk) disable iff (!rst_n)
        ($rose(st_q.gate.hi) || $rose(st_q.gate.lo)) |->
        $past(!st_q.gate.hi && !st_q.gate.lo));

    // R6: disable seen at the controller clears both gates next cycle.
    p_disable_off_r6: assert property (@(posedge clk) disable iff (!rst_n)
        dis_i |=> (!st_q.gate.hi && !st_q.gate.lo));

    // R8: any gate edge is flagged in the same cycle.
    p_event_edge_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (!$stable(st_q.gate.hi) || !$stable(st_q.gate.lo)) |-> st_q.ev);

endmodule

// File: rtl/bridge_input_cond.sv
module bridge_input_cond
    import bic_pkg::*;
#(
    parameter int NUM_PHASES = 3,
    parameter int FILT_CYC   = 15,
    parameter int DEAD_CYC   = 100
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic [NUM_PHASES-1:0] hi_cmd_n,
    input  logic [NUM_PHASES-1:0] lo_cmd_n,
    input  logic                  drv_disable,
    output logic [NUM_PHASES-1:0] hi_gate_en,
    output logic [NUM_PHASES-1:0] lo_gate_en,
    output logic [NUM_PHASES-1:0] sw_event
);

    localparam int NCMD = 2 * NUM_PHASES;

    logic [NCMD-1:0]       cmd_n_sync;
    logic [NCMD-1:0]       cmd_filt;
    logic                  dis_sync;
    gate_pair_t            gate_pair [NUM_PHASES];

    bic_sync #(.W(NCMD), .RST_VAL(1'b1)) u_cmd_sync (
        .clk     (clk),
        .rst_n   (rst_n),
        .async_i ({lo_cmd_n, hi_cmd_n}),
        .sync_o  (cmd_n_sync)
    );

    bic_sync #(.W(1), .RST_VAL(1'b1)) u_dis_sync (
        .clk     (clk),
        .rst_n   (rst_n),
        .async_i (drv_disable),
        .sync_o  (dis_sync)
    );

    for (genvar gi = 0; gi < NCMD; gi++) begin : g_filt
        bic_glitch_filter #(.FILT_CYC(FILT_CYC)) u_filt (
            .clk    (clk),
            .rst_n  (rst_n),
            .raw_i  (~cmd_n_sync[gi]),
            .filt_o (cmd_filt[gi])
        );
    end

    for (genvar gp = 0; gp < NUM_PHASES; gp++) begin : g_phase
        bic_phase_ctrl #(.DEAD_CYC(DEAD_CYC)) u_ctrl (
            .clk      (clk),
            .rst_n    (rst_n),
            .hi_req_i (cmd_filt[gp]),
            .lo_req_i (cmd_filt[NUM_PHASES + gp]),
            .dis_i    (dis_sync),
            .gate_o   (gate_pair[gp]),
            .event_o  (sw_event[gp])
        );
        assign hi_gate_en[gp] = gate_pair[gp].hi;
        assign lo_gate_en[gp] = gate_pair[gp].lo;
    end

endmodule

// File: tb/tb_bridge_input_cond.sv
module tb_bridge_input_cond;

    localparam int CLK_PERIOD = 20;
    localparam int NPH   = 3;
    localparam int FILT  = 15;
    localparam int DEAD  = 100;
    localparam int LAT   = FILT + 3;

    logic           clk = 1'b0;
    logic           rst_n = 1'b0;
    logic [NPH-1:0] hi_cmd_n = '1;
    logic [NPH-1:0] lo_cmd_n = '1;
    logic           drv_disable = 1'b0;
    logic [NPH-1:0] hi_gate_en, lo_gate_en, sw_event;

    int cyc = 0;
    int n_run = 0;
    int n_fail = 0;
    bit done = 0;

    typedef struct {
        int    at;
        int    ph;
        bit    hi;
        bit    lo;
        int    ev;     // -1: not checked
        string tag;
    } exp_t;

    exp_t sb[$];

    bridge_input_cond #(.NUM_PHASES(NPH), .FILT_CYC(FILT), .DEAD_CYC(DEAD)) dut (
        .clk         (clk),
        .rst_n       (rst_n),
        .hi_cmd_n    (hi_cmd_n),
        .lo_cmd_n    (lo_cmd_n),
        .drv_disable (drv_disable),
        .hi_gate_en  (hi_gate_en),
        .lo_gate_en  (lo_gate_en),
        .sw_event    (sw_event)
    );

    always #(CLK_PERIOD/2) clk = ~clk;
    always @(posedge clk) cyc <= cyc + 1;

    // Driver side: queue an expectation OFF cycles from now.
    task automatic expect_at(int off, int ph, bit h, bit l, int e, string tag);
        exp_t it;
        it.at = cyc + off; it.ph = ph; it.hi = h; it.lo = l; it.ev = e; it.tag = tag;
        sb.push_back(it);
    endtask

    task automatic wait_cyc(int n);
        repeat (n) @(negedge clk);
    endtask

    // Monitor: outputs only move at posedge, so compare at negedge.
    always @(negedge clk) begin
        for (int i = sb.size() - 1; i >= 0; i--) begin
            if (sb[i].at == cyc) begin
                exp_t it;
                it = sb[i];
                n_run++;
                if (hi_gate_en[it.ph] !== it.hi || lo_gate_en[it.ph] !== it.lo ||
                    (it.ev >= 0 && sw_event[it.ph] !== it.ev[0])) begin
                    n_fail++;
                    $display("FAIL %s phase %0d cyc %0d: hi/lo/ev = %b/%b/%b expected %b/%b/%0d",
                             it.tag, it.ph, cyc, hi_gate_en[it.ph], lo_gate_en[it.ph],
                             sw_event[it.ph], it.hi, it.lo, it.ev);
                end
                sb.delete(i);
            end
        end
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            n_fail++;
            $display("FAIL watchdog: run did not finish, actual hung expected done");
            $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
            $finish;
        end
    end

    initial begin
        // R1: reset state.
        wait_cyc(3);
        n_run++;
        if (hi_gate_en !== '0 || lo_gate_en !== '0 || sw_event !== '0) begin
            n_fail++;
            $display("FAIL R1 reset: hi=%b lo=%b ev=%b expected all 0",
                     hi_gate_en, lo_gate_en, sw_event);
        end
        rst_n = 1'b1;
        for (int p = 0; p < NPH; p++) expect_at(2, p, 0, 0, 0, "R1 post-reset");
        wait_cyc(DEAD + 20);

        // R2/R8: upper switch of phase A, latency and event pulse.
        hi_cmd_n[0] = 1'b0;
        expect_at(LAT - 1, 0, 0, 0, 0, "R2 before latency");
        expect_at(LAT,     0, 1, 0, 1, "R2 R8 on edge");
        expect_at(LAT + 1, 0, 1, 0, 0, "R8 single pulse");
        wait_cyc(LAT + 20);

        // R5: hand-over from upper to lower, exact dead time.
        hi_cmd_n[0] = 1'b1;
        lo_cmd_n[0] = 1'b0;
        expect_at(LAT,            0, 0, 0, 1, "R5 R8 off edge");
        expect_at(LAT + DEAD - 1, 0, 0, 0, 0, "R5 still dead");
        expect_at(LAT + DEAD,     0, 0, 1, 1, "R5 lower on");
        wait_cyc(LAT + DEAD + 10);

        // R2: glitch one cycle short of the window on phase B; R9 phase A held.
        lo_cmd_n[1] = 1'b0;
        expect_at(LAT,        1, 0, 0, 0, "R2 short glitch");
        expect_at(LAT + FILT, 1, 0, 0, 0, "R2 short glitch");
        expect_at(2 * LAT,    1, 0, 0, 0, "R2 short glitch");
        expect_at(LAT,        0, 0, 1, -1, "R9 phase A unaffected");
        wait_cyc(FILT - 1);
        lo_cmd_n[1] = 1'b1;
        wait_cyc(3 * LAT);

        // R2: pulse of exactly the window length on phase C passes.
        hi_cmd_n[2] = 1'b0;
        expect_at(LAT - 1,        2, 0, 0, 0, "R2 exact pulse pre");
        expect_at(LAT,            2, 1, 0, 1, "R2 exact pulse on");
        expect_at(LAT + FILT - 1, 2, 1, 0, -1, "R2 exact pulse width");
        expect_at(LAT + FILT,     2, 0, 0, 1, "R2 exact pulse off");
        wait_cyc(FILT);
        hi_cmd_n[2] = 1'b1;
        wait_cyc(LAT + DEAD + 10);

        // R3/R4: phase A lower is on; add upper, both must go off and stay off.
        hi_cmd_n[0] = 1'b0;
        expect_at(LAT - 1,    0, 0, 1, -1, "R3 before lockout");
        expect_at(LAT,        0, 0, 0, 1, "R3 lockout");
        expect_at(LAT + 200,  0, 0, 0, 0, "R4 lockout persists");
        wait_cyc(LAT + 250);
        lo_cmd_n[0] = 1'b1;
        expect_at(LAT - 1, 0, 0, 0, -1, "R4 lockout until release");
        expect_at(LAT,     0, 1, 0, 1, "R4 release upper on");
        wait_cyc(LAT + 20);

        // R6: disable clears phase A upper within 3 cycles.
        drv_disable = 1'b1;
        expect_at(2, 0, 1, 0, -1, "R6 before disable");
        expect_at(3, 0, 0, 0, 1, "R6 disable off");
        wait_cyc(5);
        hi_cmd_n[0] = 1'b1;
        lo_cmd_n[0] = 1'b0;
        lo_cmd_n[1] = 1'b0;
        expect_at(LAT + DEAD, 0, 0, 0, 0, "R6 ignored while disabled");
        expect_at(LAT + DEAD, 1, 0, 0, 0, "R6 ignored while disabled");
        wait_cyc(LAT + DEAD + 10);

        // R7: release, dead time must run again.
        drv_disable = 1'b0;
        expect_at(DEAD + 1, 0, 0, 0, 0, "R7 wait after release");
        expect_at(DEAD + 2, 0, 0, 1, 1, "R7 on after release");
        expect_at(DEAD + 1, 1, 0, 0, 0, "R7 wait after release");
        expect_at(DEAD + 2, 1, 0, 1, 1, "R7 on after release");
        wait_cyc(DEAD + 10);

        // R9: phase C upper on while A and B lowers stay on.
        hi_cmd_n[2] = 1'b0;
        expect_at(LAT, 2, 1, 0, 1, "R9 phase C on");
        expect_at(LAT, 0, 0, 1, 0, "R9 phase A kept");
        expect_at(LAT, 1, 0, 1, 0, "R9 phase B kept");
        wait_cyc(LAT + 10);

        if (sb.size() != 0) begin
            n_fail++;
            $display("FAIL scoreboard: %0d items left expected 0", sb.size());
        end
        done = 1;
        $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end

endmodule